// File: doc/BRIEF.md
# General-Purpose Pin Controller with Per-Pin Interrupt Detection

This block controls a bank of general-purpose pins through a small register bus with an address, separate read and write strobes, a write data word and a read data word. Each pin has an output-enable bit. Its driven level is never written directly. Instead, one address takes write-one-to-set strobes and another address takes write-one-to-clear strobes, so software can change a single pin without a read-modify-write.

Incoming pin levels pass through a two-flop synchronizer before software can read them and before any event is detected. Every pin has its own trigger detector. Three configuration bits select the trigger for each pin: level or edge, single edge or either edge, and polarity. Detected events are stored in a raw status register that ignores gating. An enable register and a mask register then gate the raw status into a masked status word. The single interrupt output is the OR of the masked status bits.

Top module: `gpio32_irq_ctrl`

## Requirements
- R1: After reset every register is zero, so `pin_out`, `pin_oe` and `irq` are low and every readable register returns 0.
- R2: Writing the direction register (byte offset 0x04) loads it. A 1 bit sets the matching `pin_oe` bit, which marks the pin as an output, from the next clock. The register reads back as written.
- R3: A write to offset 0x08 drives high every pin whose data bit is 1. A write to offset 0x0C drives low every pin whose data bit is 1. Pins whose data bit is 0 keep their level.
- R4: Offset 0x00 returns the pin inputs after a two-flop synchronizer. A change on `pin_in` becomes visible after the second rising clock edge.
- R5: With method bit 0 (offset 0x24), a pin is in edge mode. If its both-edges bit (offset 0x28) is 1, it triggers on any change. Otherwise it triggers on a rising edge when its polarity bit (offset 0x2C) is 0 and on a falling edge when that bit is 1.
- R6: In edge mode a raw status bit stays set until a 1 is written to that bit at offset 0x20. If an edge and a clear reach the same bit in the same cycle, the bit stays set.
- R7: With method bit 1, a pin's raw status follows its level. It is active when the input is high with polarity 0, or low with polarity 1. A clear write has no lasting effect while the level stays active.
- R8: The masked status (offset 0x18) equals the raw status ANDed with the enable register (offset 0x10) and with the inverse of the mask register (offset 0x1C). `irq` is high exactly when any masked status bit is 1.
- R9: The raw status (offset 0x14) records events whatever the enable and mask settings are.
- R10: Reads of offsets 0x08, 0x0C and 0x20, and of any offset not named here, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the accessed register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Driven pin levels |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as a new edge on the same pin. Only then does the edge-wins priority matter. The bench counts the pipeline from the pin change: one edge into the first flop, one into the second, and the status update on the third. It raises the clear strobe on the negative edge just before that third rising edge, then reads the bit back as set. Level-mode pins with an active level are also cleared and read back at once, to show that the clear does not last.

// File: rtl/gpio32_pkg.sv
package gpio32_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 6;

    typedef enum logic [AW-1:0] {
        A_IN     = 6'h00,
        A_DIR    = 6'h04,
        A_SET    = 6'h08,
        A_CLR    = 6'h0C,
        A_IEN    = 6'h10,
        A_RAW    = 6'h14,
        A_MST    = 6'h18,
        A_MASK   = 6'h1C,
        A_ICLR   = 6'h20,
        A_METH   = 6'h24,
        A_BOTH   = 6'h28,
        A_POL    = 6'h2C
    } reg_addr_e;

endpackage

// File: rtl/gpio32_sync.sv
module gpio32_sync #(
    parameter int unsigned NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] async_in,
    output logic [NPIN-1:0] sync_now,
    output logic [NPIN-1:0] sync_prev
);
    logic [NPIN-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q    <= '0;
            sync_now  <= '0;
            sync_prev <= '0;
        end else begin
            meta_q    <= async_in;
            sync_now  <= meta_q;
            sync_prev <= sync_now;
        end
    end
endmodule

// File: rtl/gpio32_trig.sv
module gpio32_trig (
    input  logic cur,
    input  logic prev,
    input  logic lvl_mode,
    input  logic any_edge,
    input  logic invert,
    output logic edge_hit,
    output logic lvl_hit
);
    logic rise, fall, one_edge;

    always_comb begin
        rise     = cur & ~prev;
        fall     = ~cur & prev;
        one_edge = invert ? fall : rise;
        edge_hit = ~lvl_mode & (any_edge ? (rise | fall) : one_edge);
        lvl_hit  = lvl_mode & (cur ^ invert);
    end
endmodule

// File: rtl/gpio32_irq_ctrl.sv
module gpio32_irq_ctrl
    import gpio32_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq
);
    typedef struct packed {
        logic [NPIN-1:0] level;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] ien;
        logic [NPIN-1:0] mask;
        logic [NPIN-1:0] meth;
        logic [NPIN-1:0] both;
        logic [NPIN-1:0] pol;
        logic [NPIN-1:0] raw;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [NPIN-1:0] smp_now, smp_prev;
    logic [NPIN-1:0] edge_hit, lvl_hit;
    logic [NPIN-1:0] wsel, clr_vec, masked;
    logic [NPIN-1:0] rd_sel;

    gpio32_sync #(.NPIN(NPIN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (pin_in),
        .sync_now  (smp_now),
        .sync_prev (smp_prev)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_trig
        gpio32_trig u_trig (
            .cur      (smp_now[i]),
            .prev     (smp_prev[i]),
            .lvl_mode (st_q.meth[i]),
            .any_edge (st_q.both[i]),
            .invert   (st_q.pol[i]),
            .edge_hit (edge_hit[i]),
            .lvl_hit  (lvl_hit[i])
        );
    end

    always_comb begin
        wsel    = bus_wdata[NPIN-1:0];
        clr_vec = (bus_wr && bus_addr == A_ICLR) ? wsel : '0;
        st_d    = st_q;

        if (bus_wr) begin
            case (bus_addr)
                A_DIR:   st_d.dir   = wsel;
                A_SET:   st_d.level = st_q.level | wsel;
                A_CLR:   st_d.level = st_q.level & ~wsel;
                A_IEN:   st_d.ien   = wsel;
                A_MASK:  st_d.mask  = wsel;
                A_METH:  st_d.meth  = wsel;
                A_BOTH:  st_d.both  = wsel;
                A_POL:   st_d.pol   = wsel;
                default: ;
            endcase
        end

        for (int i = 0; i < NPIN; i++) begin
            if (st_q.meth[i])
                st_d.raw[i] = lvl_hit[i];
            else
                st_d.raw[i] = edge_hit[i] | (st_q.raw[i] & ~clr_vec[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        masked = st_q.raw & st_q.ien & ~st_q.mask;
        irq    = |masked;

        case (bus_addr)
            A_IN:    rd_sel = smp_now;
            A_DIR:   rd_sel = st_q.dir;
            A_IEN:   rd_sel = st_q.ien;
            A_RAW:   rd_sel = st_q.raw;
            A_MST:   rd_sel = masked;
            A_MASK:  rd_sel = st_q.mask;
            A_METH:  rd_sel = st_q.meth;
            A_BOTH:  rd_sel = st_q.both;
            A_POL:   rd_sel = st_q.pol;
            default: rd_sel = '0;
        endcase

        bus_rdata = '0;
        if (bus_rd)
            bus_rdata[NPIN-1:0] = rd_sel;
    end

    assign pin_out = st_q.level;
    assign pin_oe  = st_q.dir;

endmodule

// File: rtl/gpio32_irq_chk.sv
module gpio32_irq_chk
    import gpio32_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] pin_oe,
    input logic            irq,
    input logic [NPIN-1:0] raw_stat,
    input logic [NPIN-1:0] ien_reg,
    input logic [NPIN-1:0] mask_reg,
    input logic [NPIN-1:0] meth_reg
);
    logic [NPIN-1:0] wd, iclr_vec;
    logic            wr_set, wr_clr, wo_rd;

    always_comb begin
        wd       = bus_wdata[NPIN-1:0];
        wr_set   = bus_wr && bus_addr == A_SET;
        wr_clr   = bus_wr && bus_addr == A_CLR;
        iclr_vec = (bus_wr && bus_addr == A_ICLR) ? wd : '0;
        wo_rd    = bus_rd && (bus_addr == A_SET || bus_addr == A_CLR || bus_addr == A_ICLR);
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_DIR |=> pin_oe == $past(wd)); // R2

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (pin_out & $past(wd)) == $past(wd)); // R3

    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (pin_out & $past(wd)) == '0); // R3

    AST_STROBE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) |=> (pin_out & ~$past(wd)) == ($past(pin_out) & ~$past(wd))); // R3

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(raw_stat) & ~raw_stat & ~$past(meth_reg) & ~$past(iclr_vec)) == '0); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_stat & ien_reg & ~mask_reg) != '0); // R8

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wo_rd |-> bus_rdata == '0); // R10

endmodule

bind gpio32_irq_ctrl gpio32_irq_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .raw_stat  (st_q.raw),
    .ien_reg   (st_q.ien),
    .mask_reg  (st_q.mask),
    .meth_reg  (st_q.meth)
);

// File: tb/gpio32_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio32_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    gpio32_irq_ctrl #(.NPIN(32)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    localparam logic [5:0] O_IN = 6'h00, O_DIR = 6'h04, O_SET = 6'h08, O_CLR = 6'h0C,
        O_IEN = 6'h10, O_RAW = 6'h14, O_MST = 6'h18, O_MASK = 6'h1C, O_ICLR = 6'h20,
        O_METH = 6'h24, O_BOTH = 6'h28, O_POL = 6'h2C;

    // {offset, data, expected pin_out, expected pin_oe}  (R2, R3)
    localparam int NV = 10;
    localparam logic [101:0] VEC [NV] = '{
        {O_SET, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000},
        {O_SET, 32'h8000_0001, 32'h8000_00F1, 32'h0000_0000},
        {O_CLR, 32'h0000_0030, 32'h8000_00C1, 32'h0000_0000},
        {O_CLR, 32'h0000_0000, 32'h8000_00C1, 32'h0000_0000},
        {O_SET, 32'h0000_0000, 32'h8000_00C1, 32'h0000_0000},
        {O_DIR, 32'hFFFF_0000, 32'h8000_00C1, 32'hFFFF_0000},
        {O_CLR, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_0000},
        {O_SET, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 32'hFFFF_0000},
        {O_DIR, 32'h0000_000F, 32'hA5A5_5A5A, 32'h0000_000F},
        {O_DIR, 32'h0000_0000, 32'hA5A5_5A5A, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(req, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rd_chk("R1 raw", O_RAW, 32'h0);
        rd_chk("R1 meth", O_METH, 32'h0);

        // R2 R3 table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][101:96], VEC[i][95:64]);
            chk($sformatf("R3 vec%0d out", i), pin_out, VEC[i][63:32]);
            chk($sformatf("R2 vec%0d oe", i), pin_oe, VEC[i][31:0]);
        end
        wr(O_DIR, 32'h1234_5678);
        rd_chk("R2 dir readback", O_DIR, 32'h1234_5678);

        // R4 synchronizer latency
        pin_in = 32'h0000_0100;
        @(negedge clk);
        rd_chk("R4 one edge", O_IN, 32'h0);
        @(negedge clk);
        rd_chk("R4 two edges", O_IN, 32'h0000_0100);
        pin_in = 32'h0;
        settle();
        // R9 rising edge on pin8 recorded with enable 0
        rd_chk("R9 raw no enable", O_RAW, 32'h0000_0100);
        rd_chk("R8 masked zero", O_MST, 32'h0);
        wr(O_ICLR, 32'hFFFF_FFFF);
        rd_chk("R6 cleared", O_RAW, 32'h0);

        // pin0 rise, pin1 fall, pin2 both, pin3 level high, pin4 level low
        wr(O_METH, 32'h18);
        wr(O_BOTH, 32'h04);
        wr(O_POL, 32'h12);
        settle();
        rd_chk("R7 level low active", O_RAW, 32'h10);
        wr(O_ICLR, 32'hFFFF_FFFF);
        rd_chk("R7 clear no effect", O_RAW, 32'h10);

        pin_in = 32'h0F;
        settle();
        rd_chk("R4 input read", O_IN, 32'h0F);
        rd_chk("R5 R7 rising set", O_RAW, 32'h1D);
        wr(O_ICLR, 32'h1F);
        rd_chk("R6 R7 partial clear", O_RAW, 32'h18);
        pin_in = 32'h10;
        settle();
        rd_chk("R5 falling set", O_RAW, 32'h06);

        // R8 gating
        chk("R8 irq no enable", {31'h0, irq}, 32'h0);
        wr(O_IEN, 32'h02);
        rd_chk("R8 masked enabled", O_MST, 32'h02);
        chk("R8 irq enabled", {31'h0, irq}, 32'h1);
        wr(O_MASK, 32'h02);
        rd_chk("R8 masked by mask", O_MST, 32'h0);
        chk("R8 irq masked", {31'h0, irq}, 32'h0);
        rd_chk("R9 raw under mask", O_RAW, 32'h06);
        wr(O_MASK, 32'h0);
        wr(O_IEN, 32'h04);
        rd_chk("R8 masked pin2", O_MST, 32'h04);
        wr(O_ICLR, 32'hFFFF_FFFF);
        rd_chk("R6 all clear", O_RAW, 32'h0);
        chk("R8 irq after clear", {31'h0, irq}, 32'h0);

        // R6 edge and clear in the same cycle on pin0
        pin_in = 32'h11;
        @(negedge clk);
        @(negedge clk);
        wr(O_ICLR, 32'h01);
        rd_chk("R6 edge wins over clear", O_RAW, 32'h01);
        wr(O_ICLR, 32'h01);
        rd_chk("R6 later clear", O_RAW, 32'h0);

        // R10 write-only and undefined offsets
        rd_chk("R10 set reads zero", O_SET, 32'h0);
        rd_chk("R10 clr reads zero", O_CLR, 32'h0);
        rd_chk("R10 iclr reads zero", O_ICLR, 32'h0);
        rd_chk("R10 undefined", 6'h3C, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule